// File: doc/BRIEF.md
# Registered Address/Control Fan-out Buffer

This block sits between a memory controller and two rank groups on a memory module. On every rising clock edge it captures an address/command bus, a set of active-low chip selects, per-rank clock enables and per-rank termination controls. It drives registered copies of these signals onto an A side and a B side.

A strap pin picks the chip-select arrangement. In dual mode, two chip-select inputs are each copied to one A-side and one B-side output. In quad mode, four chip-select inputs map straight to four outputs. The address/command bus is only taken when the cycle targets exactly one rank. Clock enables and termination controls pass through every cycle.

Real high impedance is replaced by per-group output-enable flags, which keeps the block synthesizable. The pads outside the block use these flags to tristate their drivers.

Top module: `rcd_fanout_reg`

## Requirements
- R1: Every forwarded signal appears at the outputs exactly one clock after the rising edge that captured it.
- R2: In dual mode (strap `quad_sel_ni` high), only `cs_n_i[1:0]` are considered. On a forwarding cycle, `cs_n_o[1:0]` (A side) and `cs_n_o[3:2]` (B side) both carry `cs_n_i[1:0]`, so `cs_n_o[k] = cs_n_i[k mod 2]`. The inputs `cs_n_i[3:2]` have no effect.
- R3: In quad mode (strap low), `cs_n_o[k] = cs_n_i[k]` for k = 0..3 on a forwarding cycle.
- R4: When exactly one considered chip select is low, the captured `ac_i` is driven on both `ac_a_o` and `ac_b_o`, and the two copies are always equal.
- R5: When zero, or more than one, considered chip selects are low, `ac_a_o`/`ac_b_o` keep their previous value and all `cs_n_o` bits are driven high.
- R6: `cke_i` and `odt_i` are forwarded to both the A and the B copies every cycle, whatever the chip selects are.
- R7: While `rst_ni` is low, asynchronously and independent of the clock: all clock-enable outputs are low, `oe_o` is all zero, `ac_*_o` is zero, `odt_*_o` is zero and `cs_n_o` is all ones.
- R8: All three bits of `oe_o` (bit 0 address/command, bit 1 chip select, bit 2 termination) go high at the first rising edge after `rst_ni` is released.
- R9: The strap is taken at the first rising edge after reset release, and that same edge already uses it. Later changes of the strap are ignored until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; capture on rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| quad_sel_ni | input | 1 | Mode strap: low = quad, high = dual |
| cs_n_i | input | NUM_CS (4) | Active-low chip selects |
| ac_i | input | AC_W (24) | Address/command bus |
| cke_i | input | NUM_RANK (2) | Per-rank clock enables |
| odt_i | input | NUM_RANK (2) | Per-rank termination controls |
| cs_n_o | output | NUM_CS (4) | Registered chip selects |
| ac_a_o | output | AC_W (24) | Address/command, A side |
| ac_b_o | output | AC_W (24) | Address/command, B side |
| cke_a_o | output | NUM_RANK (2) | Clock enables, A side |
| cke_b_o | output | NUM_RANK (2) | Clock enables, B side |
| odt_a_o | output | NUM_RANK (2) | Termination, A side |
| odt_b_o | output | NUM_RANK (2) | Termination, B side |
| oe_o | output | 3 | Output enables: bit 0 ac, bit 1 cs, bit 2 odt |

## Verification
Every registered result, including the output enables after release, is due one rising edge after its inputs are driven. The driver applies inputs on the falling edge and queues the expected item. The monitor pops that item just after the next rising edge, so each comparison falls in the single cycle where the result is valid.

The reset values are checked shortly after reset is asserted, before any clock edge occurs, which shows that the reset acts asynchronously. Strap changes made mid-run are checked with chip-select patterns that the two modes decode differently.

// File: rtl/rcd_pkg.sv
`timescale 1ns/1ps
package rcd_pkg;
  typedef enum logic {CS_MODE_DUAL = 1'b0, CS_MODE_QUAD = 1'b1} cs_mode_e;
  localparam int OE_GRP = 3;
  localparam int OE_AC  = 0;
  localparam int OE_CS  = 1;
  localparam int OE_ODT = 2;
endpackage

// File: rtl/rcd_mode_ctrl.sv
`timescale 1ns/1ps
module rcd_mode_ctrl
  import rcd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     quad_sel_ni,
  output cs_mode_e mode_o
);
  logic     run_q;
  cs_mode_e mode_q;
  cs_mode_e strap_mode;

  assign strap_mode = quad_sel_ni ? CS_MODE_DUAL : CS_MODE_QUAD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= CS_MODE_DUAL;
    end else begin
      run_q <= 1'b1;
      if (!run_q) mode_q <= strap_mode;
    end
  end

  // first edge after release decodes with the live strap, later edges with the held copy
  assign mode_o = run_q ? mode_q : strap_mode;
endmodule

// File: rtl/rcd_cs_route.sv
`timescale 1ns/1ps
module rcd_cs_route
  import rcd_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  cs_mode_e          mode_i,
  input  logic [NUM_CS-1:0] cs_n_i,
  output logic              hit_o,
  output logic [NUM_CS-1:0] cs_n_o
);
  localparam int HALF = NUM_CS / 2;
  localparam int CW   = $clog2(NUM_CS + 1);

  logic [NUM_CS-1:0] used_n;
  logic [NUM_CS-1:0] routed_n;
  logic [CW-1:0]     low_cnt;

  for (genvar k = 0; k < NUM_CS; k++) begin : g_lane
    if (k >= HALF) begin : g_upper
      assign used_n[k]   = (mode_i == CS_MODE_QUAD) ? cs_n_i[k] : 1'b1;
      assign routed_n[k] = (mode_i == CS_MODE_QUAD) ? cs_n_i[k] : cs_n_i[k-HALF];
    end else begin : g_lower
      assign used_n[k]   = cs_n_i[k];
      assign routed_n[k] = cs_n_i[k];
    end
  end

  always_comb begin
    low_cnt = '0;
    for (int i = 0; i < NUM_CS; i++) low_cnt = low_cnt + CW'(!used_n[i]);
  end

  assign hit_o  = (low_cnt == CW'(1));
  assign cs_n_o = hit_o ? routed_n : '1;
endmodule

// File: rtl/rcd_pipe_reg.sv
`timescale 1ns/1ps
module rcd_pipe_reg #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/rcd_fanout_reg.sv
`timescale 1ns/1ps
module rcd_fanout_reg
  import rcd_pkg::*;
#(
  parameter int AC_W     = 24,
  parameter int NUM_CS   = 4,
  parameter int NUM_RANK = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                quad_sel_ni,
  input  logic [NUM_CS-1:0]   cs_n_i,
  input  logic [AC_W-1:0]     ac_i,
  input  logic [NUM_RANK-1:0] cke_i,
  input  logic [NUM_RANK-1:0] odt_i,
  output logic [NUM_CS-1:0]   cs_n_o,
  output logic [AC_W-1:0]     ac_a_o,
  output logic [AC_W-1:0]     ac_b_o,
  output logic [NUM_RANK-1:0] cke_a_o,
  output logic [NUM_RANK-1:0] cke_b_o,
  output logic [NUM_RANK-1:0] odt_a_o,
  output logic [NUM_RANK-1:0] odt_b_o,
  output logic [OE_GRP-1:0]   oe_o
);
  localparam int NUM_SIDE = 2;

  cs_mode_e          mode;
  logic              hit;
  logic [NUM_CS-1:0] cs_next;

  logic [NUM_SIDE-1:0][AC_W-1:0]     ac_q;
  logic [NUM_SIDE-1:0][NUM_RANK-1:0] cke_q;
  logic [NUM_SIDE-1:0][NUM_RANK-1:0] odt_q;

  rcd_mode_ctrl u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .quad_sel_ni (quad_sel_ni),
    .mode_o      (mode)
  );

  rcd_cs_route #(.NUM_CS(NUM_CS)) u_route (
    .mode_i (mode),
    .cs_n_i (cs_n_i),
    .hit_o  (hit),
    .cs_n_o (cs_next)
  );

  rcd_pipe_reg #(.W(NUM_CS), .RST_VAL({NUM_CS{1'b1}})) u_cs_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (1'b1),
    .d_i    (cs_next),
    .q_o    (cs_n_o)
  );

  // one flop set per side so each side drives its own load
  for (genvar s = 0; s < NUM_SIDE; s++) begin : g_side
    rcd_pipe_reg #(.W(AC_W), .RST_VAL('0)) u_ac_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (hit),
      .d_i    (ac_i),
      .q_o    (ac_q[s])
    );
    rcd_pipe_reg #(.W(NUM_RANK), .RST_VAL('0)) u_cke_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (1'b1),
      .d_i    (cke_i),
      .q_o    (cke_q[s])
    );
    rcd_pipe_reg #(.W(NUM_RANK), .RST_VAL('0)) u_odt_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (1'b1),
      .d_i    (odt_i),
      .q_o    (odt_q[s])
    );
  end

  for (genvar g = 0; g < OE_GRP; g++) begin : g_oe
    rcd_pipe_reg #(.W(1), .RST_VAL(1'b0)) u_oe_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (1'b1),
      .d_i    (1'b1),
      .q_o    (oe_o[g])
    );
  end

  assign ac_a_o  = ac_q[0];
  assign ac_b_o  = ac_q[1];
  assign cke_a_o = cke_q[0];
  assign cke_b_o = cke_q[1];
  assign odt_a_o = odt_q[0];
  assign odt_b_o = odt_q[1];
endmodule

// File: rtl/rcd_fanout_reg_chk.sv
`timescale 1ns/1ps
module rcd_fanout_reg_chk #(
  parameter int AC_W     = 24,
  parameter int NUM_CS   = 4,
  parameter int NUM_RANK = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_CS-1:0]   cs_n_i,
  input logic [NUM_RANK-1:0] cke_i,
  input logic [NUM_RANK-1:0] odt_i,
  input logic [NUM_CS-1:0]   cs_n_o,
  input logic [AC_W-1:0]     ac_a_o,
  input logic [AC_W-1:0]     ac_b_o,
  input logic [NUM_RANK-1:0] cke_a_o,
  input logic [NUM_RANK-1:0] cke_b_o,
  input logic [NUM_RANK-1:0] odt_a_o,
  input logic [NUM_RANK-1:0] odt_b_o,
  input logic [2:0]          oe_o
);
  a_r7_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (cke_a_o == '0 && cke_b_o == '0 && oe_o == '0));

  a_r8_oe_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (&oe_o));

  a_r4_copies_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ac_a_o == ac_b_o);

  a_r5_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_n_i) |=> ($stable(ac_a_o) && (&cs_n_o)));

  a_r6_cke_odt_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (cke_a_o == $past(cke_i) && cke_b_o == $past(cke_i) &&
                odt_a_o == $past(odt_i) && odt_b_o == $past(odt_i)));
endmodule

bind rcd_fanout_reg rcd_fanout_reg_chk #(
  .AC_W(AC_W), .NUM_CS(NUM_CS), .NUM_RANK(NUM_RANK)
) chk_i (.*);

// File: tb/rcd_fanout_reg_tb_top.sv
`timescale 1ns/1ps
module rcd_fanout_reg_tb_top;
  localparam int AC_W = 24;

  typedef struct packed {
    logic [AC_W-1:0] ac;
    logic [3:0]      cs;
    logic [1:0]      cke;
    logic [1:0]      odt;
  } exp_t;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            quad_sel_ni = 1'b1;
  logic [3:0]      cs_n_i = 4'hF;
  logic [AC_W-1:0] ac_i = '0;
  logic [1:0]      cke_i = '0;
  logic [1:0]      odt_i = '0;
  logic [3:0]      cs_n_o;
  logic [AC_W-1:0] ac_a_o, ac_b_o;
  logic [1:0]      cke_a_o, cke_b_o, odt_a_o, odt_b_o;
  logic [2:0]      oe_o;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   quad_m = 1'b0;
  logic [AC_W-1:0] hold_ac = '0;
  exp_t q[$];

  always #2.5 clk_i = ~clk_i;

  rcd_fanout_reg dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] cs, input logic [AC_W-1:0] ac, input logic [1:0] cke, input logic [1:0] odt);
    exp_t e;
    int   lows;
    logic [3:0] rt;
    @(negedge clk_i);
    cs_n_i = cs; ac_i = ac; cke_i = cke; odt_i = odt;
    lows = 0;
    for (int i = 0; i < 4; i++) if ((quad_m || i < 2) && !cs[i]) lows++;
    for (int k = 0; k < 4; k++) rt[k] = quad_m ? cs[k] : cs[k % 2];
    if (lows == 1) begin
      hold_ac = ac;
      e.cs = rt;
    end else e.cs = 4'hF;
    e.ac = hold_ac; e.cke = cke; e.odt = odt;
    q.push_back(e);
  endtask

  // R7 async reset, R9 strap at release, R8 enables
  task automatic do_reset(input logic strap);
    @(negedge clk_i);
    #0.5 rst_ni = 1'b0;
    #0.5;
    chk(cke_a_o == 0 && cke_b_o == 0, "R7 cke low async", {cke_a_o, cke_b_o}, 0);
    chk(oe_o == 0, "R7 oe off async", oe_o, 0);
    quad_sel_ni = strap; cs_n_i = 4'hF; ac_i = '0; cke_i = '0; odt_i = '0;
    repeat (3) @(negedge clk_i);
    chk(ac_a_o == 0 && ac_b_o == 0, "R7 ac reset", ac_a_o, 0);
    chk(cs_n_o == 4'hF, "R7 cs reset", cs_n_o, 4'hF);
    chk(odt_a_o == 0 && odt_b_o == 0, "R7 odt reset", {odt_a_o, odt_b_o}, 0);
    chk(cke_a_o == 0 && cke_b_o == 0, "R7 cke reset", {cke_a_o, cke_b_o}, 0);
    rst_ni = 1'b1;
    quad_m = !strap;
    hold_ac = '0;
    q.push_back('{ac: '0, cs: 4'hF, cke: 2'b00, odt: 2'b00});
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk_i);
      #1;
      if (rst_ni && q.size() > 0) begin
        e = q.pop_front();
        chk(ac_a_o == e.ac, "R4/R5 ac_a", ac_a_o, e.ac);
        chk(ac_b_o == e.ac, "R4 ac_b", ac_b_o, e.ac);
        chk(cs_n_o == e.cs, "R2/R3/R5 cs", cs_n_o, e.cs);
        chk(cke_a_o == e.cke && cke_b_o == e.cke, "R6/R1 cke", {cke_a_o, cke_b_o}, {e.cke, e.cke});
        chk(odt_a_o == e.odt && odt_b_o == e.odt, "R6/R1 odt", {odt_a_o, odt_b_o}, {e.odt, e.odt});
        chk(oe_o == 3'b111, "R8 oe", oe_o, 3'b111);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    // dual mode
    do_reset(1'b1);
    drive(4'b1110, 24'hA0A0A1, 2'b01, 2'b10); // R2 cs0 to both sides
    drive(4'b1101, 24'hB1B2B3, 2'b10, 2'b01); // R2 cs1
    drive(4'b1100, 24'hDEAD01, 2'b11, 2'b11); // R5 two low, hold
    drive(4'b1111, 24'hDEAD02, 2'b00, 2'b00); // R5 none low, R6 still forwarded
    drive(4'b0110, 24'h123456, 2'b01, 2'b01); // R2 upper lanes ignored
    drive(4'b0011, 24'h654321, 2'b10, 2'b00); // R2 upper only -> hold
    @(negedge clk_i) quad_sel_ni = 1'b0;      // R9 strap change ignored
    drive(4'b1011, 24'h777777, 2'b11, 2'b10);
    drive(4'b1110, 24'h0F0F0F, 2'b00, 2'b11);
    // quad mode
    do_reset(1'b0);
    drive(4'b1110, 24'h111111, 2'b01, 2'b00); // R3
    drive(4'b1011, 24'h222222, 2'b10, 2'b01); // R3
    drive(4'b0111, 24'h333333, 2'b11, 2'b10); // R3
    drive(4'b0110, 24'h444444, 2'b00, 2'b11); // R5 two low
    drive(4'b1111, 24'h555555, 2'b01, 2'b01); // R5 none
    drive(4'b1101, 24'h666666, 2'b10, 2'b10); // R3
    @(negedge clk_i) quad_sel_ni = 1'b1;      // R9 strap change ignored
    drive(4'b0111, 24'h888888, 2'b11, 2'b00);
    for (int i = 0; i < 40; i++)
      drive(4'($urandom), AC_W'($urandom), 2'($urandom), 2'($urandom));
    // back to dual with random traffic
    do_reset(1'b1);
    for (int i = 0; i < 40; i++)
      drive(4'($urandom), AC_W'($urandom), 2'($urandom), 2'($urandom));
    repeat (3) @(negedge clk_i);
    chk(q.size() == 0, "R1 all items seen", q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule